// File: doc/BRIEF.md
# Dual-Bus Burst-of-Two SRAM Port

This block models one port of a quad-data-rate static memory. The port has a write-data bus that only enters the block and a read-data bus that only leaves it. Both buses carry one 36-bit word on each edge of a single primary clock. One address bus is shared in time: it holds the read address at the rising edge and the write address at the falling edge. Each address names a pair of words, and the pair always moves as a burst of two. Read and write commands use active-low selects. A command counts only when a two-bit device-select field matches the port's own identity, which lets several ports share one command bus.

A write takes its first data word and four byte enables at the rising edge. It takes its address, its second data word and a second set of byte enables at the next falling edge, and then updates the array. A read takes its address at a rising edge. One full cycle later, word 0 drives the output bus during the high phase of the clock and word 1 drives it during the low phase. A valid flag is high for both words, and an echo strobe changes level with every word sent. Because the write lands before the read looks up the array, a read and a write to the same address in the same cycle return the new bytes. The output timing always follows the primary clock, which is the mode used when the separate output clock pair is tied off.

Top module: `qdr_burst_port`

## Requirements
- R1: While reset is low and afterwards until the first accepted read, `q` is zero, `q_valid` is 0 and `q_echo` is 0.
- R2: A read accepted at rising edge N (`rd_n` low and `dev_sel` equal to `DEV_ID`) puts word 0 of the addressed pair on `q` with `q_valid` high during the high phase after rising edge N+1. Word 1 follows with `q_valid` high during the low phase after that.
- R3: A write accepted at rising edge N takes word 0 from `d` at that edge. It takes the write address from `addr` and word 1 from `d` at the following falling edge, and a later read returns both words.
- R4: Byte lane k is bits [9k+8:9k] of a word. A lane is written only when `bw_n[k]` is 0 at the edge that captures that word, and a lane with `bw_n[k]` at 1 keeps its old contents.
- R5: A read or write whose `dev_sel` differs from `DEV_ID` has no effect: no valid output and no change to any stored word.
- R6: A read and a write may be accepted at the same rising edge. When both use the same address, the read returns the bytes just written merged with the bytes kept.
- R7: While no read word is being sent, `q` keeps the last word it carried and `q_valid` is 0.
- R8: `q_echo` changes level once for each word sent and keeps its level while no word is sent.
- R9: Reads accepted on consecutive rising edges give an unbroken stream of words with `q_valid` high on every half-cycle.
- R10: A cycle with both `rd_n` and `wr_n` high changes no stored word and sends no word, whatever the address, data and byte enables are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Primary clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| rd_n | input | 1 | Active-low read select, taken at the rising edge |
| wr_n | input | 1 | Active-low write select, taken at the rising edge |
| dev_sel | input | SEL_W | Device-select field, compared with `DEV_ID` at the rising edge |
| addr | input | $clog2(DEPTH) | Read address at the rising edge, write address at the falling edge |
| d | input | WORD_W | Write data: word 0 at the rising edge, word 1 at the falling edge |
| bw_n | input | LANES | Active-low byte-lane write enables, taken with each data word |
| q | output | WORD_W | Read data: word 0 in the high phase, word 1 in the low phase |
| q_valid | output | 1 | High while `q` carries a read word |
| q_echo | output | 1 | Echo strobe; changes level with each word sent |

## Verification
A wrong array entry or lane merge only shows up when that address is read. It then appears on `q` a cycle and a half to two cycles after the read select, so the bench writes every address and reads it back with every byte-mask pattern. A stuck or misaligned read pipeline shows up as a missing or extra valid half-cycle, or as an echo level out of step, within two edges of the read. A word-0/word-1 mix-up shows as swapped data in the two phases of the same cycle. A leaking hold path shows as a changed `q` on a half-cycle with `q_valid` low.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

   typedef struct packed {
      logic rd;
      logic wr;
   } qbp_req_t;

   function automatic qbp_req_t qbp_decode(input logic rd_sel_n, input logic wr_sel_n,
                                           input logic id_hit);
      qbp_req_t r;
      r.rd = id_hit && !rd_sel_n;
      r.wr = id_hit && !wr_sel_n;
      return r;
   endfunction

endpackage

// File: rtl/qbp_cmd_capture.sv
module qbp_cmd_capture
   import qbp_pkg::*;
#(
   parameter int AW     = 4,
   parameter int WORD_W = 36,
   parameter int LANES  = 4,
   parameter int SEL_W  = 2,
   parameter int DEV_ID = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [SEL_W-1:0]  dev_sel,
   input  logic [AW-1:0]     addr,
   input  logic [WORD_W-1:0] d,
   input  logic [LANES-1:0]  bw_n,
   output logic              rd_pend,
   output logic [AW-1:0]     rd_addr,
   output logic              wr_pend,
   output logic [WORD_W-1:0] wr_w0,
   output logic [LANES-1:0]  wr_bw0
);
   localparam logic [SEL_W-1:0] MY_ID = SEL_W'(DEV_ID);

   qbp_req_t req;

   always_comb req = qbp_decode(rd_n, wr_n, dev_sel == MY_ID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         wr_pend <= 1'b0;
         rd_addr <= '0;
         wr_w0   <= '0;
         wr_bw0  <= '1;
      end else begin
         rd_pend <= req.rd;
         wr_pend <= req.wr;
         rd_addr <= addr;
         wr_w0   <= d;
         wr_bw0  <= bw_n;
      end
   end
endmodule

// File: rtl/qbp_burst_store.sv
module qbp_burst_store #(
   parameter int AW     = 4,
   parameter int DEPTH  = 16,
   parameter int WORD_W = 36,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              wr_pend,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_w0,
   input  logic [LANES-1:0]  wr_bw0,
   input  logic [WORD_W-1:0] wr_w1,
   input  logic [LANES-1:0]  wr_bw1,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_w0,
   output logic [WORD_W-1:0] rd_w1
);
   localparam int LANE_W = WORD_W / LANES;

   logic [WORD_W-1:0] bank0 [DEPTH];
   logic [WORD_W-1:0] bank1 [DEPTH];
   logic [WORD_W-1:0] keep0, keep1;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign keep0[g*LANE_W +: LANE_W] = {LANE_W{wr_bw0[g]}};
      assign keep1[g*LANE_W +: LANE_W] = {LANE_W{wr_bw1[g]}};
   end

   // The write lands on the falling edge, ahead of any read lookup at the next rising edge.
   always_ff @(negedge clk) begin
      if (wr_pend) begin
         bank0[wr_addr] <= (bank0[wr_addr] & keep0) | (wr_w0 & ~keep0);
         bank1[wr_addr] <= (bank1[wr_addr] & keep1) | (wr_w1 & ~keep1);
      end
   end

   assign rd_w0 = bank0[rd_addr];
   assign rd_w1 = bank1[rd_addr];
endmodule

// File: rtl/qbp_ddr_out.sv
module qbp_ddr_out #(
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] w0,
   input  logic [WORD_W-1:0] w1,
   output logic [WORD_W-1:0] rise_data,
   output logic [WORD_W-1:0] fall_data,
   output logic              rise_val,
   output logic              fall_val,
   output logic              rise_echo,
   output logic              fall_echo
);
   logic [WORD_W-1:0] second_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_data <= '0;
         second_q  <= '0;
         rise_val  <= 1'b0;
         rise_echo <= 1'b0;
      end else if (load) begin
         rise_data <= w0;
         second_q  <= w1;
         rise_val  <= 1'b1;
         rise_echo <= ~fall_echo;
      end else begin
         rise_data <= fall_data;
         rise_val  <= 1'b0;
         rise_echo <= fall_echo;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fall_data <= '0;
         fall_val  <= 1'b0;
         fall_echo <= 1'b0;
      end else if (rise_val) begin
         fall_data <= second_q;
         fall_val  <= 1'b1;
         fall_echo <= ~rise_echo;
      end else begin
         fall_data <= rise_data;
         fall_val  <= 1'b0;
         fall_echo <= rise_echo;
      end
   end
endmodule

// File: rtl/qdr_burst_port.sv
module qdr_burst_port #(
   parameter int WORD_W = 36,
   parameter int LANES  = 4,
   parameter int DEPTH  = 16,
   parameter int SEL_W  = 2,
   parameter int DEV_ID = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_n,
   input  logic                     wr_n,
   input  logic [SEL_W-1:0]         dev_sel,
   input  logic [$clog2(DEPTH)-1:0] addr,
   input  logic [WORD_W-1:0]        d,
   input  logic [LANES-1:0]         bw_n,
   output logic [WORD_W-1:0]        q,
   output logic                     q_valid,
   output logic                     q_echo
);
   localparam int AW = $clog2(DEPTH);

   if (WORD_W % LANES != 0) begin : g_bad_lanes
      $error("WORD_W must split evenly into LANES");
   end
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DEV_ID < 0 || DEV_ID >= (1 << SEL_W)) begin : g_bad_id
      $error("DEV_ID does not fit in SEL_W bits");
   end

   logic              rd_pend, wr_pend;
   logic [AW-1:0]     rd_addr;
   logic [WORD_W-1:0] wr_w0, rd_w0, rd_w1;
   logic [LANES-1:0]  wr_bw0;
   logic [WORD_W-1:0] rise_data, fall_data;
   logic              rise_val, fall_val, rise_echo, fall_echo;

   qbp_cmd_capture #(.AW(AW), .WORD_W(WORD_W), .LANES(LANES), .SEL_W(SEL_W), .DEV_ID(DEV_ID))
   u_cap (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .dev_sel(dev_sel),
      .addr(addr), .d(d), .bw_n(bw_n),
      .rd_pend(rd_pend), .rd_addr(rd_addr), .wr_pend(wr_pend),
      .wr_w0(wr_w0), .wr_bw0(wr_bw0)
   );

   qbp_burst_store #(.AW(AW), .DEPTH(DEPTH), .WORD_W(WORD_W), .LANES(LANES))
   u_store (
      .clk(clk), .wr_pend(wr_pend), .wr_addr(addr),
      .wr_w0(wr_w0), .wr_bw0(wr_bw0), .wr_w1(d), .wr_bw1(bw_n),
      .rd_addr(rd_addr), .rd_w0(rd_w0), .rd_w1(rd_w1)
   );

   qbp_ddr_out #(.WORD_W(WORD_W))
   u_out (
      .clk(clk), .rst_n(rst_n), .load(rd_pend), .w0(rd_w0), .w1(rd_w1),
      .rise_data(rise_data), .fall_data(fall_data),
      .rise_val(rise_val), .fall_val(fall_val),
      .rise_echo(rise_echo), .fall_echo(fall_echo)
   );

   // Double-rate output: the rising-edge register drives the high phase, the falling-edge one the low phase.
   assign q       = clk ? rise_data : fall_data;
   assign q_valid = clk ? rise_val  : fall_val;
   assign q_echo  = clk ? rise_echo : fall_echo;
endmodule

// File: rtl/qdr_burst_port_chk.sv
module qdr_burst_port_chk #(
   parameter int WORD_W = 36,
   parameter int SEL_W  = 2,
   parameter int DEV_ID = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_n,
   input logic [SEL_W-1:0]  dev_sel,
   input logic              rise_val,
   input logic              fall_val,
   input logic              rise_echo,
   input logic              fall_echo,
   input logic [WORD_W-1:0] fall_data
);
   logic rd_req;
   assign rd_req = !rd_n && (dev_sel == SEL_W'(DEV_ID));

   // R2
   rd_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> ##2 rise_val);
   // R5
   no_stray_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |-> ##2 !rise_val);
   // R2
   rd_word1_chk: assert property (@(negedge clk) disable iff (!rst_n)
      rise_val |=> fall_val);
   // R7
   fall_idle_chk: assert property (@(negedge clk) disable iff (!rst_n)
      !rise_val |=> !fall_val);
   // R7
   hold_data_chk: assert property (@(negedge clk) disable iff (!rst_n)
      !rise_val |=> $stable(fall_data));
   // R8
   echo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_val == (rise_echo != fall_echo));
endmodule

bind qdr_burst_port qdr_burst_port_chk #(.WORD_W(WORD_W), .SEL_W(SEL_W), .DEV_ID(DEV_ID)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .dev_sel(dev_sel),
   .rise_val(rise_val), .fall_val(fall_val),
   .rise_echo(rise_echo), .fall_echo(fall_echo), .fall_data(fall_data)
);

// File: tb/qdr_burst_port_bench.sv
module qdr_burst_port_bench;
   localparam int WW = 36;
   localparam int NL = 4;
   localparam int DP = 16;
   localparam logic [1:0] ID = 2'd1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0]    dev_sel = 2'd0;
   logic [3:0]    addr = '0;
   logic [WW-1:0] d = '0;
   logic [NL-1:0] bw_n = '1;
   logic [WW-1:0] q;
   logic          q_valid, q_echo;

   int checks = 0, fails = 0, edge_no = 0;
   bit done = 0;

   logic [WW-1:0] ref0 [DP];
   logic [WW-1:0] ref1 [DP];
   bit            exp_v  [64];
   logic [WW-1:0] exp0   [64];
   logic [WW-1:0] exp1   [64];
   string         exp_tag[64];

   qdr_burst_port #(.WORD_W(WW), .LANES(NL), .DEPTH(DP), .SEL_W(2), .DEV_ID(1)) u_qdr_burst_port (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .dev_sel(dev_sel),
      .addr(addr), .d(d), .bw_n(bw_n), .q(q), .q_valid(q_valid), .q_echo(q_echo)
   );

   always #4 clk = ~clk;
   always @(posedge clk) edge_no++;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [WW-1:0] act, input logic [WW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic logic [WW-1:0] pat(input int a, input int w, input int salt);
      logic [WW-1:0] v;
      v = (WW'(salt) << 28) ^ (WW'(a) << 16) ^ (WW'(w) << 12) ^ WW'(a * 73 + salt * 911 + w * 5);
      return v;
   endfunction

   function automatic logic [WW-1:0] merge(input logic [WW-1:0] old, input logic [WW-1:0] nw,
                                           input logic [NL-1:0] bn);
      logic [WW-1:0] r = old;
      for (int l = 0; l < NL; l++)
         if (!bn[l]) r[l*9 +: 9] = nw[l*9 +: 9];
      return r;
   endfunction

   // One clock cycle of stimulus: read address and word 0 before the rising edge, write address and word 1 after it.
   task automatic cyc(input logic rdn, input logic wrn, input logic [1:0] ds, input int ra, input int wa,
                      input logic [WW-1:0] w0, input logic [WW-1:0] w1,
                      input logic [NL-1:0] b0, input logic [NL-1:0] b1, input string tag);
      int slot;
      @(negedge clk); #1;
      rd_n = rdn; wr_n = wrn; dev_sel = ds; addr = 4'(ra); d = w0; bw_n = b0;
      @(posedge clk); #1;
      slot = edge_no % 64;
      if (!wrn && ds == ID) begin
         ref0[wa] = merge(ref0[wa], w0, b0);
         ref1[wa] = merge(ref1[wa], w1, b1);
      end
      exp_v[slot]   = !rdn && ds == ID;
      exp0[slot]    = ref0[ra];
      exp1[slot]    = ref1[ra];
      exp_tag[slot] = tag;
      addr = 4'(wa); d = w1; bw_n = b1;
   endtask

   task automatic rd(input int a, input string tag);
      cyc(1'b0, 1'b1, ID, a, 0, '0, '0, '1, '1, tag);
   endtask

   task automatic idle(input string tag);
      cyc(1'b1, 1'b1, ID, 0, 0, '0, '0, '1, '1, tag);
   endtask

   // Output monitor: word 0 in the high phase, word 1 in the low phase, one cycle after the read edge.
   initial begin : mon
      logic [WW-1:0] last = '0;
      logic          echo_e = 1'b0;
      int s;
      forever begin
         @(posedge clk); #2;
         if (done) break;
         s = (edge_no - 1) % 64;
         if (exp_v[s]) begin
            echo_e = ~echo_e;
            chk(q_valid === 1'b1, exp_tag[s], "valid word0", {35'd0, q_valid}, 36'd1);
            chk(q === exp0[s], exp_tag[s], "data word0", q, exp0[s]);
            last = exp0[s];
         end else begin
            chk(q_valid === 1'b0, exp_tag[s] == "" ? "R7" : exp_tag[s], "idle valid high", {35'd0, q_valid}, 36'd0);
            chk(q === last, "R7", "held data high phase", q, last);
         end
         chk(q_echo === echo_e, "R8", "echo high phase", {35'd0, q_echo}, {35'd0, echo_e});
         @(negedge clk); #2;
         if (exp_v[s]) begin
            echo_e = ~echo_e;
            chk(q_valid === 1'b1, exp_tag[s], "valid word1", {35'd0, q_valid}, 36'd1);
            chk(q === exp1[s], exp_tag[s], "data word1", q, exp1[s]);
            last = exp1[s];
         end else begin
            chk(q_valid === 1'b0, "R7", "idle valid low", {35'd0, q_valid}, 36'd0);
            chk(q === last, "R7", "held data low phase", q, last);
         end
         chk(q_echo === echo_e, "R8", "echo low phase", {35'd0, q_echo}, {35'd0, echo_e});
      end
   end

   initial begin : watchdog
      #(200000 * 8);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : drv
      #10;
      chk(q === '0 && q_valid === 1'b0 && q_echo === 1'b0, "R1", "outputs in reset", q, '0);
      #19 rst_n = 1'b1;
      @(posedge clk); #2;
      chk(q === '0 && q_valid === 1'b0 && q_echo === 1'b0, "R1", "outputs after reset", q, '0);

      // R3: full writes of every address, then read each back
      for (int a = 0; a < DP; a++) cyc(1'b1, 1'b0, ID, 0, a, pat(a, 0, 1), pat(a, 1, 1), '0, '0, "R3");
      for (int a = 0; a < DP; a++) begin rd(a, "R3"); idle("R7"); end

      // R4: every mask pattern on each word across the addresses
      for (int a = 0; a < DP; a++)
         cyc(1'b1, 1'b0, ID, 0, a, pat(a, 0, 2), pat(a, 1, 2), 4'(a), ~4'(a), "R4");
      for (int a = 0; a < DP; a++) rd(a, "R4");

      // R5: commands for other device ids are ignored
      for (int s = 0; s < 4; s++)
         if (2'(s) != ID)
            for (int a = 0; a < DP; a++)
               cyc(1'b0, 1'b0, 2'(s), a, a, pat(a, 0, 3 + s), pat(a, 1, 3 + s), '0, '0, "R5");
      for (int a = 0; a < DP; a++) rd(a, "R5");

      // R6: read and write in one cycle, same address and a different one
      for (int a = 0; a < DP; a++)
         cyc(1'b0, 1'b0, ID, a, a, pat(a, 0, 9), pat(a, 1, 9), 4'b0101, 4'b1010, "R6");
      for (int a = 0; a < DP; a++)
         cyc(1'b0, 1'b0, ID, a, (a + 5) % DP, pat(a, 0, 10), pat(a, 1, 10), '0, '0, "R6");

      // R10: idle selects with busy buses
      for (int a = 0; a < DP; a++)
         cyc(1'b1, 1'b1, ID, a, DP - 1 - a, pat(a, 0, 11), pat(a, 1, 11), '0, '0, "R10");
      for (int a = 0; a < DP; a++) rd(a, "R10");

      // R9: continuous reads with a write every cycle
      for (int a = 0; a < 2 * DP; a++)
         cyc(1'b0, 1'b0, ID, (a + 3) % DP, a % DP, pat(a, 0, 12), pat(a, 1, 12), 4'(a * 3), 4'(a * 5), "R9");

      for (int i = 0; i < 4; i++) idle("R7");
      done = 1;
      @(posedge clk); #5;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule